// File: doc/BRIEF.md
# SRAM Error-Correcting Controller with Partial-Write Merge

This block sits between a simple request/response bus port and a single-port SRAM. The SRAM is 39 bits wide: each 32-bit data word is stored with 7 check bits of a single-error-correct, double-error-detect code. Full-word writes are encoded and stored at once. A 64-bit write is stored as two consecutive words. Byte and halfword writes cannot update the check bits in place, so the controller reads the old word, corrects it, merges the new bytes, re-encodes the word and writes it back. Reads are decoded, and a single flipped bit is repaired on the fly.

A separate logging unit keeps sticky flags for corrected and uncorrectable events, together with the address and syndrome of the latest event. It pulses a fault output for every uncorrectable event. For test, a flip mask can be loaded. The mask is XORed into the next stored codeword only and is then dropped.

The control FSM has seven states. IDLE accepts a request and chooses the next state. For a full-word write, IDLE goes to WR_ACK. For a 64-bit write it goes to DW_HI, which stores the upper word. For a read it goes to RD_DATA. For a partial write it goes to RMW_RD. RMW_RD goes to RMW_WR on a clean or corrected read, or to RMW_FAIL on an uncorrectable one. WR_ACK, DW_HI, RD_DATA, RMW_WR and RMW_FAIL each give the response and return to IDLE.

Top module: `sram_ecc_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, both sticky flags and fault are 0, and err_addr is 0.
- R2: A write with req_be = 4'b1111 stores the word and responds with rsp_err = 0 in the cycle after acceptance (zero wait states).
- R3: A write with req_dw = 1 stores req_wdata[31:0] at req_addr and req_wdata[63:32] at req_addr+1 (wrapping), and responds in the cycle after acceptance. req_ready is 0 in that cycle.
- R4: A read responds in the cycle after acceptance with the stored 32-bit word.
- R5: A write with any other req_be (bit n selects byte n, bits 8n+7..8n) replaces only the enabled bytes, keeps the rest, and responds one wait state later.
- R6: If any one of the 39 stored bits is flipped, a read still returns the original data with rsp_err = 0 and no extra wait state, and ce_flag is set.
- R7: If two stored bits are flipped, a read returns rsp_err = 1, ue_flag is set, and fault pulses for exactly one cycle.
- R8: A partial write whose old word holds an uncorrectable error responds with rsp_err = 1 after one wait state and leaves the SRAM word unchanged.
- R9: On every event, err_addr takes the word address and err_syn takes {overall parity mismatch, 6-bit position}. The codeword layout is: bit 0 is overall parity; bits 1, 2, 4, 8, 16 and 32 are check bits; data bit j sits at the j-th remaining index in ascending order. A single flip of stored bit k gives err_syn = {1, k}. Two flips give {0, k1 XOR k2}.
- R10: err_clr[0] clears ce_flag and err_clr[1] clears ue_flag. Each flag stays set until cleared.
- R11: A mask loaded with inj_load is XORed into the next codeword written to the SRAM only, and is then discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; the request is accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_dw | input | 1 | 64-bit write |
| req_be | input | 4 | Byte enables for 32-bit writes |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data (upper half used only by 64-bit writes) |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Uncorrectable error on this access |
| rsp_rdata | output | 32 | Corrected read data |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_wdata | output | 39 | Codeword to store |
| sram_rdata | input | 39 | Codeword read, valid one cycle after the access |
| inj_load | input | 1 | Load the flip mask |
| inj_mask | input | 39 | Bits to flip in the next stored codeword |
| err_clr | input | 2 | Write-one-to-clear: bit 0 corrected, bit 1 uncorrectable |
| ce_flag | output | 1 | Sticky corrected-error flag |
| ue_flag | output | 1 | Sticky uncorrectable-error flag |
| err_addr | output | ADDR_W | Address of the latest event |
| err_syn | output | 7 | Syndrome of the latest event |
| fault | output | 1 | One-cycle pulse per uncorrectable event |

## Verification
The bench flips each of the 39 stored bits in turn and checks the syndrome position for each. A layout mismatch or a missed parity-bit case would return wrong data or a wrong position. It runs a partial write over a word with two flipped bits. A controller that fails to abort that write would silently store a freshly encoded, wrong word, and the bench catches this by comparing the SRAM contents before and after. Other cases are a 64-bit write at the top address, where a bad increment fails to wrap, and a flip mask that must reach only the first of two writes, where a mask that stays loaded shows up in the second word.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;
    localparam int POS_W  = 6;
    localparam int CW_W   = DATA_W + POS_W + 1;
    localparam int SYN_W  = POS_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_ACK,
        ST_DW_HI,
        ST_RD_DATA,
        ST_RMW_RD,
        ST_RMW_WR,
        ST_RMW_FAIL
    } ctl_state_t;
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);
    logic [CW_W-1:0]  cw;
    logic [POS_W-1:0] syn;
    int j;

    always_comb begin
        cw = '0;
        j  = 0;
        // place data bits at non-power-of-two indices
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = data_i[j];
                j++;
            end
        end
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p]) syn = syn ^ POS_W'(p);
        end
        for (int i = 0; i < POS_W; i++) begin
            cw[1 << i] = syn[i];
        end
        cw[0] = ^cw[CW_W-1:1];
        cw_o  = cw;
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import ecc_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ce_o,
    output logic              ue_o,
    output logic [SYN_W-1:0]  syn_o
);
    logic [POS_W-1:0] s;
    logic             pe;
    logic [CW_W-1:0]  fixed;
    int j;

    always_comb begin
        s = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw_i[p]) s = s ^ POS_W'(p);
        end
        pe   = ^cw_i;
        ce_o = pe && (int'(s) < CW_W);
        ue_o = (!pe && (s != '0)) || (pe && (int'(s) >= CW_W));
        fixed = cw_i;
        for (int p = 0; p < CW_W; p++) begin
            if (ce_o && (int'(s) == p)) fixed[p] = ~fixed[p];
        end
        data_o = '0;
        j = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                data_o[j] = fixed[p];
                j++;
            end
        end
        syn_o = {pe, s};
    end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              ce_in,
    input  logic              ue_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [SYN_W-1:0]  syn_in,
    input  logic [1:0]        clr,
    output logic              ce_flag,
    output logic              ue_flag,
    output logic [ADDR_W-1:0] err_addr,
    output logic [SYN_W-1:0]  err_syn,
    output logic              fault
);
    logic ce_ev, ue_ev;

    assign ce_ev = chk_valid && ce_in;
    assign ue_ev = chk_valid && ue_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_flag  <= 1'b0;
            ue_flag  <= 1'b0;
            err_addr <= '0;
            err_syn  <= '0;
            fault    <= 1'b0;
        end else begin
            // a new event wins over a clear in the same cycle
            ce_flag <= (ce_flag && !clr[0]) || ce_ev;
            ue_flag <= (ue_flag && !clr[1]) || ue_ev;
            fault   <= ue_ev;
            if (ce_ev || ue_ev) begin
                err_addr <= addr_in;
                err_syn  <= syn_in;
            end
        end
    end

    assert_fault_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ue_flag);

    assert_ce_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_flag && !clr[0]) |=> ce_flag);
endmodule

// File: rtl/sram_ecc_ctrl.sv
module sram_ecc_ctrl
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_we,
    input  logic                  req_dw,
    input  logic [BYTES-1:0]      req_be,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2*DATA_W-1:0]   req_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  sram_en,
    output logic                  sram_we,
    output logic [ADDR_W-1:0]     sram_addr,
    output logic [CW_W-1:0]       sram_wdata,
    input  logic [CW_W-1:0]       sram_rdata,
    input  logic                  inj_load,
    input  logic [CW_W-1:0]       inj_mask,
    input  logic [1:0]            err_clr,
    output logic                  ce_flag,
    output logic                  ue_flag,
    output logic [ADDR_W-1:0]     err_addr,
    output logic [SYN_W-1:0]      err_syn,
    output logic                  fault
);
    ctl_state_t state_q, state_d;

    logic [ADDR_W-1:0]   addr_q;
    logic [2*DATA_W-1:0] wdata_q;
    logic [BYTES-1:0]    be_q;
    logic [DATA_W-1:0]   merged_q, merged_d;
    logic [CW_W-1:0]     inj_q;

    logic [DATA_W-1:0]   enc_data;
    logic [CW_W-1:0]     enc_cw;
    logic [DATA_W-1:0]   dec_data;
    logic                dec_ce, dec_ue;
    logic [SYN_W-1:0]    dec_syn;
    logic                accept, chk_valid;

    secded_enc u_enc (
        .data_i (enc_data),
        .cw_o   (enc_cw)
    );

    secded_dec u_dec (
        .cw_i   (sram_rdata),
        .data_o (dec_data),
        .ce_o   (dec_ce),
        .ue_o   (dec_ue),
        .syn_o  (dec_syn)
    );

    assign chk_valid = (state_q == ST_RD_DATA) || (state_q == ST_RMW_RD);

    ecc_err_log #(.ADDR_W(ADDR_W)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_valid (chk_valid),
        .ce_in     (dec_ce),
        .ue_in     (dec_ue),
        .addr_in   (addr_q),
        .syn_in    (dec_syn),
        .clr       (err_clr),
        .ce_flag   (ce_flag),
        .ue_flag   (ue_flag),
        .err_addr  (err_addr),
        .err_syn   (err_syn),
        .fault     (fault)
    );

    // byte merge of corrected old word with new bytes
    for (genvar b = 0; b < BYTES; b++) begin : g_merge
        assign merged_d[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
    end

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign sram_wdata = enc_cw ^ inj_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture, merge result and injection mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
            merged_q <= '0;
            inj_q    <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            if (state_q == ST_RMW_RD) merged_q <= merged_d;
            if (inj_load)     inj_q <= inj_mask;
            else if (sram_we) inj_q <= '0;
        end
    end

    // outputs and next state
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        sram_en   = 1'b0;
        sram_we   = 1'b0;
        sram_addr = addr_q;
        enc_data  = req_wdata[DATA_W-1:0];
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                sram_addr = req_addr;
                if (req_valid) begin
                    sram_en = 1'b1;
                    if (!req_we) begin
                        state_d = ST_RD_DATA;
                    end else if (req_dw) begin
                        sram_we = 1'b1;
                        state_d = ST_DW_HI;
                    end else if (req_be == '1) begin
                        sram_we = 1'b1;
                        state_d = ST_WR_ACK;
                    end else begin
                        state_d = ST_RMW_RD;
                    end
                end
            end
            ST_WR_ACK: begin
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_DW_HI: begin
                sram_en   = 1'b1;
                sram_we   = 1'b1;
                sram_addr = addr_q + 1'b1;
                enc_data  = wdata_q[2*DATA_W-1:DATA_W];
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_RD_DATA: begin
                rsp_valid = 1'b1;
                rsp_err   = dec_ue;
                rsp_rdata = dec_data;
                state_d   = ST_IDLE;
            end
            ST_RMW_RD: begin
                state_d = dec_ue ? ST_RMW_FAIL : ST_RMW_WR;
            end
            ST_RMW_WR: begin
                sram_en   = 1'b1;
                sram_we   = 1'b1;
                enc_data  = merged_q;
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_RMW_FAIL: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_word_nowait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_we && !req_dw && (req_be == '1)) |=> (rsp_valid && !rsp_err));

    assert_dw_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_we && req_dw) |=>
            (sram_we && !req_ready && (sram_addr == ADDR_W'($past(req_addr) + 1'b1))));

    assert_read_nowait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_we) |=> rsp_valid);

    assert_rmw_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RMW_RD) && dec_ue) |=> (!sram_we && rsp_valid && rsp_err));

    assert_inject_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && !inj_load) |=> (inj_q == '0));
endmodule

// File: tb/tb_sram_ecc_ctrl.sv
module tb_sram_ecc_ctrl;
    localparam int AW = 4;
    localparam int CW = 39;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_we = 1'b0, req_dw = 1'b0;
    logic [3:0]    req_be = '0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_err;
    logic [31:0]   rsp_rdata;
    logic          sram_en, sram_we;
    logic [AW-1:0] sram_addr;
    logic [CW-1:0] sram_wdata, sram_rdata;
    logic          inj_load = 1'b0;
    logic [CW-1:0] inj_mask = '0;
    logic [1:0]    err_clr = '0;
    logic          ce_flag, ue_flag, fault;
    logic [AW-1:0] err_addr;
    logic [6:0]    err_syn;

    logic          flip_en = 1'b0;
    logic [AW-1:0] flip_addr = '0;
    logic [CW-1:0] flip_mask = '0;
    logic [CW-1:0] mem [16];
    int            fault_cnt = 0;
    int            errors = 0;
    int            checks = 0;

    always #2.5 clk = ~clk;

    sram_ecc_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_dw(req_dw),
        .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .inj_load(inj_load), .inj_mask(inj_mask), .err_clr(err_clr),
        .ce_flag(ce_flag), .ue_flag(ue_flag), .err_addr(err_addr),
        .err_syn(err_syn), .fault(fault)
    );

    // SRAM model with a bench-side bit-flip port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            sram_rdata <= '0;
        end else begin
            if (flip_en) mem[flip_addr] <= mem[flip_addr] ^ flip_mask;
            if (sram_en) begin
                if (sram_we) mem[sram_addr] <= sram_wdata;
                else         sram_rdata     <= mem[sram_addr];
            end
        end
    end

    always @(negedge clk) if (rst_n && fault) fault_cnt++;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic dw, input logic [3:0] be,
                          input logic [AW-1:0] a, input logic [63:0] d,
                          output int waits, output logic [31:0] rd,
                          output logic er, output logic rdy1);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_dw = dw; req_be = be;
        req_addr = a; req_wdata = d;
        n = 0; rdy1 = 1'b1;
        do begin
            @(negedge clk);
            if (n == 0) begin
                req_valid = 1'b0;
                rdy1 = req_ready;
            end
            n++;
        end while (!rsp_valid && n < 10);
        waits = n - 1;
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic flip(input logic [AW-1:0] a, input logic [CW-1:0] m);
        @(negedge clk);
        flip_en = 1'b1; flip_addr = a; flip_mask = m;
        @(negedge clk);
        flip_en = 1'b0;
    endtask

    task automatic clear(input logic [1:0] v);
        @(negedge clk);
        err_clr = v;
        @(negedge clk);
        err_clr = '0;
    endtask

    // {we, dw, be[3:0], addr[3:0], data[63:0], expected read[31:0], waits[1:0]}
    localparam logic [107:0] VEC [14] = '{
        {1'b1, 1'b0, 4'hF, 4'd1,  64'h0000_0000_A5A5_1234, 32'h0,         2'd0},
        {1'b0, 1'b0, 4'h0, 4'd1,  64'h0,                   32'hA5A5_1234, 2'd0},
        {1'b1, 1'b1, 4'h0, 4'd2,  64'h0BAD_F00D_CAFE_BEEF, 32'h0,         2'd0},
        {1'b0, 1'b0, 4'h0, 4'd2,  64'h0,                   32'hCAFE_BEEF, 2'd0},
        {1'b0, 1'b0, 4'h0, 4'd3,  64'h0,                   32'h0BAD_F00D, 2'd0},
        {1'b1, 1'b0, 4'h1, 4'd1,  64'h0000_0000_0000_0077, 32'h0,         2'd1},
        {1'b0, 1'b0, 4'h0, 4'd1,  64'h0,                   32'hA5A5_1277, 2'd0},
        {1'b1, 1'b0, 4'hC, 4'd2,  64'h0000_0000_1111_0000, 32'h0,         2'd1},
        {1'b0, 1'b0, 4'h0, 4'd2,  64'h0,                   32'h1111_BEEF, 2'd0},
        {1'b1, 1'b0, 4'h6, 4'd3,  64'h0000_0000_0022_3300, 32'h0,         2'd1},
        {1'b0, 1'b0, 4'h0, 4'd3,  64'h0,                   32'h0B22_330D, 2'd0},
        {1'b1, 1'b1, 4'h0, 4'd15, 64'h89AB_CDEF_0123_4567, 32'h0,         2'd0},
        {1'b0, 1'b0, 4'h0, 4'd0,  64'h0,                   32'h89AB_CDEF, 2'd0},
        {1'b0, 1'b0, 4'h0, 4'd15, 64'h0,                   32'h0123_4567, 2'd0}
    };

    function automatic string tag(input logic [107:0] v);
        if (!v[107])               return "R4";
        if (v[106])                return "R3";
        if (v[105:102] == 4'hF)    return "R2";
        return "R5";
    endfunction

    initial begin
        int          w, fc;
        logic [31:0] rd;
        logic        er, r1;
        logic [CW-1:0] saved;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 flags", 64'({ce_flag, ue_flag, fault}), 64'd0);
        check("R1 err_addr", 64'(err_addr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R2 R3 R4 R5
        for (int i = 0; i < 14; i++) begin
            logic [107:0] v;
            v = VEC[i];
            do_req(v[107], v[106], v[105:102], v[101:98], v[97:34], w, rd, er, r1);
            check({tag(v), " waits"}, 64'(w), 64'(v[1:0]));
            check({tag(v), " err"}, 64'(er), 64'd0);
            if (!v[107]) check({tag(v), " rdata"}, 64'(rd), 64'(v[33:2]));
            if (v[107] && v[106]) check("R3 ready low", 64'(r1), 64'd0);
        end

        // R6 / R9 / R10: every single-bit flip is corrected and located
        do_req(1'b1, 1'b0, 4'hF, 4'd5, 64'h5A5A_C3C3, w, rd, er, r1);
        for (int k = 0; k < CW; k++) begin
            flip(4'd5, CW'(1) << k);
            do_req(1'b0, 1'b0, 4'h0, 4'd5, 64'h0, w, rd, er, r1);
            check("R6 data", 64'(rd), 64'h5A5A_C3C3);
            check("R6 err", 64'(er), 64'd0);
            check("R6 waits", 64'(w), 64'd0);
            repeat (2) @(negedge clk);
            check("R6 ce_flag", 64'(ce_flag), 64'd1);
            check("R9 syndrome", 64'(err_syn), 64'({1'b1, 6'(k)}));
            check("R9 addr", 64'(err_addr), 64'd5);
            flip(4'd5, CW'(1) << k);
            clear(2'b01);
            check("R10 ce cleared", 64'(ce_flag), 64'd0);
        end

        // R7: double flip
        fc = fault_cnt;
        flip(4'd5, (CW'(1) << 3) | (CW'(1) << 20));
        do_req(1'b0, 1'b0, 4'h0, 4'd5, 64'h0, w, rd, er, r1);
        check("R7 err", 64'(er), 64'd1);
        repeat (2) @(negedge clk);
        check("R7 ue_flag", 64'(ue_flag), 64'd1);
        check("R7 fault pulses", 64'(fault_cnt - fc), 64'd1);
        check("R9 double syndrome", 64'(err_syn), 64'd23);
        check("R10 ce untouched", 64'(ce_flag), 64'd0);

        // R8: partial write over uncorrectable word is aborted
        saved = mem[5];
        fc = fault_cnt;
        do_req(1'b1, 1'b0, 4'h1, 4'd5, 64'hFF, w, rd, er, r1);
        check("R8 err", 64'(er), 64'd1);
        check("R8 waits", 64'(w), 64'd1);
        repeat (2) @(negedge clk);
        check("R8 sram unchanged", 64'(mem[5]), 64'(saved));
        check("R8 fault", 64'(fault_cnt - fc), 64'd1);
        clear(2'b10);
        check("R10 ue cleared", 64'(ue_flag), 64'd0);

        // R11: injection hits the next write only
        @(negedge clk);
        inj_load = 1'b1; inj_mask = CW'(1) << 10;
        @(negedge clk);
        inj_load = 1'b0;
        do_req(1'b1, 1'b0, 4'hF, 4'd6, 64'hDEAD_0001, w, rd, er, r1);
        do_req(1'b1, 1'b0, 4'hF, 4'd7, 64'hDEAD_0001, w, rd, er, r1);
        check("R11 stored difference", 64'(mem[6] ^ mem[7]), 64'(CW'(1) << 10));
        do_req(1'b0, 1'b0, 4'h0, 4'd6, 64'h0, w, rd, er, r1);
        check("R11 corrected data", 64'(rd), 64'hDEAD_0001);
        repeat (2) @(negedge clk);
        check("R11 syndrome", 64'(err_syn), 64'h4A);
        clear(2'b01);
        do_req(1'b0, 1'b0, 4'h0, 4'd7, 64'h0, w, rd, er, r1);
        repeat (2) @(negedge clk);
        check("R11 second write clean", 64'(ce_flag), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule